// File: doc/BRIEF.md
# E1 Framing Error and Remote Alarm Monitor

This block sits behind an E1 framer that has already found frame alignment. For every received frame, the framer hands it one strobe. With the strobe come a flag that tells an alignment-word frame from a non-alignment-word frame, the received 8-bit word, and the expected 7-bit alignment pattern. A separate level input gives the current in-frame status.

The block keeps a saturating count of errored words. It raises a sticky flag on every change of the in-frame status. It also filters the far-end alarm bit carried in non-alignment words, and reports each change of the filtered value through a second sticky flag.

Software reaches the block through a small register port. Reading the count clears it in the same operation. Status flags are cleared by writing ones. A mask register selects which flags drive the interrupt line.

Top module: `e1_alarm_mon`

## Requirements
- R1: After a synchronous active-low reset, the error count is 0, both flags are 0, the mask is 0, the filtered alarm `ra_state` is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Word bit numbering is `frm_word[7]` = bit 1 through `frm_word[0]` = bit 8. An alignment frame (`frm_is_fas`=1) is errored when `frm_word[6:0]` differs from `fas_pattern`. `frm_word[7]` is ignored.
- R3: A non-alignment frame (`frm_is_fas`=0) is errored when `frm_word[6]` (bit 2) is 0. Its other bits do not affect the count.
- R4: Errored frames that arrive while `in_frame` is 0 are not counted.
- R5: The error count is 13 bits wide and saturates at 8191.
- R6: A read of address 0 returns the count in `bus_rdata[12:0]` on the cycle after `bus_rd` and clears the count. If an errored frame arrives in the same cycle as the read, the count afterwards is 1.
- R7: Every change of `in_frame` sets the out-of-frame flag (status bit 0). The status held during reset counts as out of frame.
- R8: The far-end alarm is `frm_word[5]` (bit 3) of non-alignment frames received in frame. `ra_state` takes a new value only after 3 consecutive such frames carry that value. A frame carrying the current value, or a period out of frame, restarts the run.
- R9: Every change of `ra_state` sets the alarm-change flag (status bit 1). Status bit 2 reads `in_frame` and status bit 3 reads `ra_state`, at address 1.
- R10: Flags stay set until software writes a 1 to the matching bit of address 1.
- R11: `irq` is high exactly when some flag is set and its mask bit is set. The mask is written and read at address 2: bit 0 for the out-of-frame flag, bit 1 for the alarm-change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| frm_is_fas | input | 1 | 1 = alignment-word frame, 0 = non-alignment frame |
| frm_word | input | 8 | Received word, bit 1 in the MSB |
| fas_pattern | input | 7 | Expected alignment bits 2..8 |
| in_frame | input | 1 | Framer in-frame status |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Masked interrupt |
| ra_state | output | 1 | Filtered far-end alarm |

## Verification
A wrong count shows up at the very next read of address 0. A missed step, a lost concurrent error or a wrap past 8191 each changes the returned value by a known amount. A wrong alarm run length shows on `ra_state` and on status bit 1 after the second or third qualifying frame, one edge after its strobe. A flag that is lost, cleared without a write, or masked wrongly shows on `irq` and on the status read within one cycle.

// File: rtl/e1_alarm_pkg.sv
// Shared constants for the E1 alarm monitor: register addresses and flag slots.
package e1_alarm_pkg;
    typedef enum logic [1:0] {
        REG_ERRCNT = 2'd0,
        REG_STAT   = 2'd1,
        REG_MASK   = 2'd2,
        REG_RSVD   = 2'd3
    } reg_addr_e;

    localparam int FLG_OOF   = 0;
    localparam int FLG_RA    = 1;
    localparam int NUM_FLAGS = 2;

    localparam int WORD_W = 8;
    localparam int PAT_W  = WORD_W - 1;
    localparam int BIT2_IDX = WORD_W - 2;   // bit 2 of the word, MSB-first numbering
    localparam int BIT3_IDX = WORD_W - 3;   // bit 3 of the word
endpackage

// File: rtl/e1_err_counter.sv
// Classifies each received word as errored or not and keeps a saturating count.
// Assumes one strobe per frame and an already aligned stream; clr comes from a
// register read and takes effect in the same edge as any concurrent error.
module e1_err_counter
    import e1_alarm_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             is_fas,
    input  logic [WORD_W-1:0] word,
    input  logic [PAT_W-1:0] pattern,
    input  logic             in_frame,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic errored;
    logic hit;

    // Decide whether the presented word violates its expected content.
    always_comb begin
        if (is_fas)
            errored = (word[PAT_W-1:0] != pattern);
        else
            errored = !word[BIT2_IDX];
        hit = stb && in_frame && errored;
    end

    // Count errored words, saturating, with clear-on-read priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= hit ? CNT_ONE : '0;
        else if (hit && cnt != CNT_MAX)
            cnt <= cnt + CNT_ONE;
    end

    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
    a_r4_hold_oof: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !clr) |=> $stable(cnt));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt <= CNT_ONE);
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_ONE));
endmodule

// File: rtl/e1_ra_filter.sv
// Persistence filter for the far-end alarm bit of non-alignment frames.
// Assumes in_frame is the framer's level; leaving frame discards a partial run.
module e1_ra_filter #(
    parameter int PERSIST = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic is_fas,
    input  logic ra_bit,
    input  logic in_frame,
    output logic ra_state,
    output logic ra_chg
);
    localparam int RUN_W = $clog2(PERSIST + 1);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(PERSIST);

    logic             cand;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] next_run;
    logic             sample_en;

    // Work out the run length this sample would reach and whether it is accepted.
    always_comb begin
        sample_en = stb && !is_fas && in_frame;
        next_run  = (run != '0 && cand == ra_bit) ? run + RUN_ONE : RUN_ONE;
        ra_chg    = sample_en && (ra_bit != ra_state) && (next_run == RUN_END);
    end

    // Track the candidate value, its run length and the accepted value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand     <= 1'b0;
            run      <= '0;
            ra_state <= 1'b0;
        end else if (!in_frame) begin
            run <= '0;
        end else if (sample_en) begin
            if (ra_bit == ra_state) begin
                run <= '0;
            end else if (ra_chg) begin
                ra_state <= ra_bit;
                run      <= '0;
            end else begin
                cand <= ra_bit;
                run  <= next_run;
            end
        end
    end

    a_r8_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run < RUN_END);
    a_r8_only_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(ra_state));
endmodule

// File: rtl/e1_irq_ctl.sv
// Sticky event flags with write-one-to-clear, a mask register and the irq output.
// Assumes set and clear arrive as single-cycle requests; set wins a tie.
module e1_irq_ctl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         irq
);
    // One sticky flag per event source.
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
                flags[i] <= 1'b0;
        end

        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(clr_we && clr_bits[i])) |=> flags[i]);
        a_r10_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end

    // Hold the software mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_we)
            mask <= mask_wdata;
    end

    // Combine flags with their enables.
    always_comb irq = |(flags & mask);
endmodule

// File: rtl/e1_alarm_mon.sv
// Top of the E1 framing error and far-end alarm monitor. Decodes the register
// port, detects in-frame changes and wires the counter, filter and flags.
// Assumes an aligned framer upstream; addresses: 0 count, 1 status, 2 mask.
module e1_alarm_mon
    import e1_alarm_pkg::*;
#(
    parameter int CNT_W   = 13,
    parameter int PERSIST = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_stb,
    input  logic              frm_is_fas,
    input  logic [WORD_W-1:0] frm_word,
    input  logic [PAT_W-1:0]  fas_pattern,
    input  logic              in_frame,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              ra_state
);
    logic                 in_frame_q;
    logic                 oof_chg;
    logic                 ra_chg;
    logic                 cnt_clr;
    logic [CNT_W-1:0]     cnt;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] mask;
    logic                 stat_we;
    logic                 mask_we;

    // Remember the previous in-frame level; reset state is out of frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_frame_q <= 1'b0;
        else
            in_frame_q <= in_frame;
    end

    // Decode register accesses and collect flag events.
    always_comb begin
        oof_chg          = in_frame ^ in_frame_q;
        cnt_clr          = bus_rd && (bus_addr == REG_ERRCNT);
        stat_we          = bus_wr && (bus_addr == REG_STAT);
        mask_we          = bus_wr && (bus_addr == REG_MASK);
        set_vec          = '0;
        set_vec[FLG_OOF] = oof_chg;
        set_vec[FLG_RA]  = ra_chg;
    end

    e1_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (frm_stb),
        .is_fas   (frm_is_fas),
        .word     (frm_word),
        .pattern  (fas_pattern),
        .in_frame (in_frame),
        .clr      (cnt_clr),
        .cnt      (cnt)
    );

    e1_ra_filter #(.PERSIST(PERSIST)) u_ra (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (frm_stb),
        .is_fas   (frm_is_fas),
        .ra_bit   (frm_word[BIT3_IDX]),
        .in_frame (in_frame),
        .ra_state (ra_state),
        .ra_chg   (ra_chg)
    );

    e1_irq_ctl #(.N(NUM_FLAGS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (set_vec),
        .clr_we     (stat_we),
        .clr_bits   (bus_wdata[NUM_FLAGS-1:0]),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata[NUM_FLAGS-1:0]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    // Capture read data one cycle after the request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                REG_ERRCNT: bus_rdata <= DATA_W'(cnt);
                REG_STAT:   bus_rdata <= DATA_W'({ra_state, in_frame, flags});
                REG_MASK:   bus_rdata <= DATA_W'(mask);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    a_r7_oof_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame != in_frame_q) |=> flags[FLG_OOF]);
    a_r9_ra_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_state != $past(ra_state)) |-> flags[FLG_RA]);
    a_r11_no_unmasked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: tb/test_e1_alarm_mon.sv
`timescale 1ns/1ps
module test_e1_alarm_mon;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_stb, frm_is_fas, in_frame, bus_rd, bus_wr;
    logic [7:0]  frm_word;
    logic [6:0]  fas_pattern;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        irq, ra_state;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    e1_alarm_mon i_e1_alarm_mon (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_is_fas(frm_is_fas),
        .frm_word(frm_word), .fas_pattern(fas_pattern), .in_frame(in_frame),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ra_state(ra_state)
    );

    // {is_fas, word[7:0], expected count after one frame}
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 8'b0001_1011, 1'b0},   // R2 good alignment word
        {1'b1, 8'b1001_1011, 1'b0},   // R2 bit 1 ignored
        {1'b1, 8'b0001_1010, 1'b1},   // R2 bit 8 wrong
        {1'b1, 8'b0101_1011, 1'b1},   // R2 bit 2 wrong
        {1'b0, 8'b0100_0000, 1'b0},   // R3 bit 2 set
        {1'b0, 8'b0111_1111, 1'b0},   // R3 other bits ignored
        {1'b0, 8'b1011_1111, 1'b1},   // R3 bit 2 clear
        {1'b0, 8'b0000_0000, 1'b1}    // R3 bit 2 clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame(input logic fas, input logic [7:0] w);
        @(negedge clk);
        frm_stb = 1'b1; frm_is_fas = fas; frm_word = w;
        @(negedge clk);
        frm_stb = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; frm_stb = 0; frm_is_fas = 0; frm_word = 0; in_frame = 0;
        fas_pattern = 7'b001_1011; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 ra_state", ra_state, 0);
        chk("R1 rdata", bus_rdata, 0);
        rd(2'd0, d); chk("R1 count", d, 0);
        rd(2'd2, d); chk("R1 mask", d, 0);
        rd(2'd1, d); chk("R1 status", d, 0);

        // R7: entering frame from the reset state sets the flag
        @(negedge clk); in_frame = 1'b1;
        @(negedge clk);
        rd(2'd1, d); chk("R7 enter frame", d[2:0], 3'b101);
        wr(2'd1, 16'h0001);
        rd(2'd1, d); chk("R10 clear oof flag", d[1:0], 2'b00);

        // R2/R3 table walk: each frame then a clearing read
        for (int k = 0; k < 8; k++) begin
            frame(VEC[k][9], VEC[k][8:1]);
            rd(2'd0, d);
            chk((k < 4) ? "R2 table" : "R3 table", d, {15'd0, VEC[k][0]});
        end
        chk("R8 broken run keeps state", ra_state, 0);

        // R4: out of frame no counting
        @(negedge clk); in_frame = 1'b0;
        frame(1'b1, 8'h00);
        rd(2'd0, d); chk("R4 no count oof", d, 0);
        rd(2'd1, d); chk("R7 leave frame", d[2:0], 3'b001);
        @(negedge clk); in_frame = 1'b1;

        // R6: error concurrent with clearing read
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        @(negedge clk);
        frm_stb = 1'b1; frm_is_fas = 1'b1; frm_word = 8'h00;
        bus_rd = 1'b1; bus_addr = 2'd0;
        @(negedge clk);
        frm_stb = 1'b0; bus_rd = 1'b0;
        chk("R6 read value", bus_rdata, 2);
        rd(2'd0, d); chk("R6 concurrent error kept", d, 1);

        // R5: saturation
        @(negedge clk);
        frm_stb = 1'b1; frm_is_fas = 1'b0; frm_word = 8'h00;
        repeat (8195) @(negedge clk);
        frm_stb = 1'b0;
        rd(2'd0, d); chk("R5 saturate", d, 8191);
        rd(2'd0, d); chk("R6 cleared after read", d, 0);

        // R8/R9: three-frame persistence
        wr(2'd1, 16'h0003);
        frame(1'b0, 8'b0110_0000);
        frame(1'b1, 8'b0001_1011);
        frame(1'b0, 8'b0110_0000);
        chk("R8 two frames no change", ra_state, 0);
        rd(2'd1, d); chk("R9 no flag yet", d[1], 0);
        frame(1'b0, 8'b0110_0000);
        chk("R8 third frame accepted", ra_state, 1);
        rd(2'd1, d); chk("R9 flag and state", d[3:0], 4'b1110);

        // R11: masking
        chk("R11 masked off", irq, 0);
        wr(2'd2, 16'h0002);
        chk("R11 ra enabled", irq, 1);
        rd(2'd2, d); chk("R11 mask readback", d, 2);
        wr(2'd2, 16'h0001);
        chk("R11 oof enabled only", irq, 0);

        // R10: stickiness and clear
        repeat (5) @(negedge clk);
        rd(2'd1, d); chk("R10 sticky", d[1], 1);
        wr(2'd1, 16'h0002);
        rd(2'd1, d); chk("R10 cleared", d[1], 0);

        // R8: out of frame breaks a run, then return to 0
        frame(1'b0, 8'b0100_0000);
        frame(1'b0, 8'b0100_0000);
        @(negedge clk); in_frame = 1'b0;
        @(negedge clk); in_frame = 1'b1;
        frame(1'b0, 8'b0100_0000);
        chk("R8 oof restarts run", ra_state, 1);
        frame(1'b0, 8'b0100_0000);
        frame(1'b0, 8'b0100_0000);
        chk("R8 returns to zero", ra_state, 0);
        chk("R11 oof flag drives irq", irq, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule